// File: doc/BRIEF.md
# Aliased Register Bank Read Decoder

This block is the read path of a memory-mapped control register bank. A requester presents an offset, an access size in bytes, a write flag and a valid strobe. One cycle later the block answers with a valid strobe, a 64-bit little-endian data word and an error flag. The register contents come in on value ports from the rest of the device, and the block only selects among them. Writes are handled elsewhere, so the block answers every write with an error.

The decoded window is 128 KiB. Offset bit 16 is dropped before decode, so the upper 64 KiB page mirrors the lower one. Four registers are 64 bits wide. They can be read whole with an 8-byte access, or as two 4-byte halves. Offsets that decode to nothing read as zero with no error, and this keeps probing software harmless.

Top module: `regbank_rd_decode`

## Requirements
- R1: After reset, rsp_valid, rsp_data and rsp_error are all zero. Every accepted request (req_valid high at a rising edge) produces exactly one response cycle with rsp_valid high on the next edge. A cycle with no request produces rsp_valid low.
- R2: Offset bit 16 is ignored. An offset with bit 16 set returns the same data and error as the same offset with bit 16 clear.
- R3: A read whose req_size is neither 4 nor 8 returns rsp_error=1 and rsp_data=0.
- R4: Any request with req_write=1 returns rsp_error=1 and rsp_data=0, whatever its size or offset.
- R5: A 4-byte read places the register in rsp_data[31:0] with bits 63:32 zero and rsp_error=0. The 32-bit map is as follows. Control 0 is at 0x020, its acknowledge at 0x024, control 1 at 0x028 and control 2 at 0x02C. Status is at 0x040. The error flags are at 0x060 and the error acknowledge at 0x064. Error configuration 1 and 2 are at 0x070 and 0x074. The stream table configuration is at 0x088. The command queue producer and consumer are at 0x098 and 0x09C. The event queue producer and consumer are at 0x0A8 and 0x0AC.
- R6: The four 64-bit registers sit at these bases: error configuration 0 at 0x068, stream table base at 0x080, command queue base at 0x090 and event queue base at 0x0A0. A 4-byte read at the base returns bits 31:0 of the register, and a 4-byte read at base+4 returns bits 63:32.
- R7: An 8-byte read at one of the four 64-bit bases returns the whole 64-bit value. An 8-byte read at any other offset returns zero with rsp_error=0.
- R8: A 4-byte read at an offset outside the map returns zero with rsp_error=0. This includes an offset that is not 4-byte aligned.
- R9: The interrupt control register reads back the same stored value at 0x050 and at its acknowledge offset 0x054.
- R10: There are six identification words at offsets 0x000 to 0x014. Word i is at offset 4*i and comes from id_vals[32*i+31:32*i]. Offset 0x018 is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | Request is a write |
| req_size | input | 4 | Access size in bytes |
| req_offset | input | 17 | Byte offset in the window |
| id_vals | input | 192 | Six identification words, word i at bits 32*i+31:32*i |
| ctrl0_val | input | 32 | Control 0 |
| ctrl0_ack_val | input | 32 | Control 0 acknowledge |
| ctrl1_val | input | 32 | Control 1 |
| ctrl2_val | input | 32 | Control 2 |
| status_val | input | 32 | Status |
| irq_ctrl_val | input | 32 | Interrupt control |
| err_val | input | 32 | Error flags |
| err_ack_val | input | 32 | Error acknowledge |
| err_cfg0_val | input | 64 | Error configuration 0 |
| err_cfg1_val | input | 32 | Error configuration 1 |
| err_cfg2_val | input | 32 | Error configuration 2 |
| stab_base_val | input | 64 | Stream table base |
| stab_cfg_val | input | 32 | Stream table configuration |
| cmdq_base_val | input | 64 | Command queue base |
| cmdq_prod_val | input | 32 | Command queue producer |
| cmdq_cons_val | input | 32 | Command queue consumer |
| evq_base_val | input | 64 | Event queue base |
| evq_prod_val | input | 32 | Event queue producer |
| evq_cons_val | input | 32 | Event queue consumer |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 64 | Read data |
| rsp_error | output | 1 | Error response |

## Verification
Every register input carries a distinct value, and each 64-bit register has different upper and lower halves. A wrong select, a swapped half or a missing upper-zero fill therefore shows up as a data mismatch. Each register is read as a 4-byte access at both halves and, for the 64-bit registers, as an 8-byte access. The same reads are then repeated with bit 16 set, which separates a correct mirror from a decode that treats the upper page as unmapped. Unmapped, misaligned and 8-byte-on-narrow-register reads must return zero with no error. Bad sizes and writes must return an error, and these cases tell the quiet zero path apart from the error path.

// File: rtl/regbank_rd_decode.sv
module regbank_rd_decode #(
  parameter int OFF_W     = 17,
  parameter int ALIAS_BIT = 16,
  parameter int NUM_ID    = 6,
  parameter int RW        = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [3:0]           req_size,
  input  logic [OFF_W-1:0]     req_offset,
  input  logic [NUM_ID*RW-1:0] id_vals,
  input  logic [RW-1:0]        ctrl0_val,
  input  logic [RW-1:0]        ctrl0_ack_val,
  input  logic [RW-1:0]        ctrl1_val,
  input  logic [RW-1:0]        ctrl2_val,
  input  logic [RW-1:0]        status_val,
  input  logic [RW-1:0]        irq_ctrl_val,
  input  logic [RW-1:0]        err_val,
  input  logic [RW-1:0]        err_ack_val,
  input  logic [2*RW-1:0]      err_cfg0_val,
  input  logic [RW-1:0]        err_cfg1_val,
  input  logic [RW-1:0]        err_cfg2_val,
  input  logic [2*RW-1:0]      stab_base_val,
  input  logic [RW-1:0]        stab_cfg_val,
  input  logic [2*RW-1:0]      cmdq_base_val,
  input  logic [RW-1:0]        cmdq_prod_val,
  input  logic [RW-1:0]        cmdq_cons_val,
  input  logic [2*RW-1:0]      evq_base_val,
  input  logic [RW-1:0]        evq_prod_val,
  input  logic [RW-1:0]        evq_cons_val,
  output logic                 rsp_valid,
  output logic [2*RW-1:0]      rsp_data,
  output logic                 rsp_error
);
  localparam int DW = 2 * RW;
  localparam logic [OFF_W-1:0] O_CTRL0     = OFF_W'(12'h020);
  localparam logic [OFF_W-1:0] O_CTRL0_ACK = OFF_W'(12'h024);
  localparam logic [OFF_W-1:0] O_CTRL1     = OFF_W'(12'h028);
  localparam logic [OFF_W-1:0] O_CTRL2     = OFF_W'(12'h02C);
  localparam logic [OFF_W-1:0] O_STATUS    = OFF_W'(12'h040);
  localparam logic [OFF_W-1:0] O_IRQ       = OFF_W'(12'h050);
  localparam logic [OFF_W-1:0] O_IRQ_ACK   = OFF_W'(12'h054);
  localparam logic [OFF_W-1:0] O_ERR       = OFF_W'(12'h060);
  localparam logic [OFF_W-1:0] O_ERR_ACK   = OFF_W'(12'h064);
  localparam logic [OFF_W-1:0] O_ECFG0     = OFF_W'(12'h068);
  localparam logic [OFF_W-1:0] O_ECFG1     = OFF_W'(12'h070);
  localparam logic [OFF_W-1:0] O_ECFG2     = OFF_W'(12'h074);
  localparam logic [OFF_W-1:0] O_STAB      = OFF_W'(12'h080);
  localparam logic [OFF_W-1:0] O_STAB_CFG  = OFF_W'(12'h088);
  localparam logic [OFF_W-1:0] O_CMDQ      = OFF_W'(12'h090);
  localparam logic [OFF_W-1:0] O_CMDQ_PROD = OFF_W'(12'h098);
  localparam logic [OFF_W-1:0] O_CMDQ_CONS = OFF_W'(12'h09C);
  localparam logic [OFF_W-1:0] O_EVQ       = OFF_W'(12'h0A0);
  localparam logic [OFF_W-1:0] O_EVQ_PROD  = OFF_W'(12'h0A8);
  localparam logic [OFF_W-1:0] O_EVQ_CONS  = OFF_W'(12'h0AC);

  logic [OFF_W-1:0] off;
  logic [RW-1:0]    rd32;
  logic [DW-1:0]    rd64;
  logic             size4, size8, nxt_err;
  logic [DW-1:0]    nxt_data;

  always_comb begin
    off = req_offset;
    off[ALIAS_BIT] = 1'b0;
  end

  assign size4 = (req_size == 4'd4);
  assign size8 = (req_size == 4'd8);

  always_comb begin
    rd32 = '0;
    case (off)
      O_CTRL0:             rd32 = ctrl0_val;
      O_CTRL0_ACK:         rd32 = ctrl0_ack_val;
      O_CTRL1:             rd32 = ctrl1_val;
      O_CTRL2:             rd32 = ctrl2_val;
      O_STATUS:            rd32 = status_val;
      O_IRQ, O_IRQ_ACK:    rd32 = irq_ctrl_val;
      O_ERR:               rd32 = err_val;
      O_ERR_ACK:           rd32 = err_ack_val;
      O_ECFG0:             rd32 = err_cfg0_val[RW-1:0];
      O_ECFG0 + 4:         rd32 = err_cfg0_val[DW-1:RW];
      O_ECFG1:             rd32 = err_cfg1_val;
      O_ECFG2:             rd32 = err_cfg2_val;
      O_STAB:              rd32 = stab_base_val[RW-1:0];
      O_STAB + 4:          rd32 = stab_base_val[DW-1:RW];
      O_STAB_CFG:          rd32 = stab_cfg_val;
      O_CMDQ:              rd32 = cmdq_base_val[RW-1:0];
      O_CMDQ + 4:          rd32 = cmdq_base_val[DW-1:RW];
      O_CMDQ_PROD:         rd32 = cmdq_prod_val;
      O_CMDQ_CONS:         rd32 = cmdq_cons_val;
      O_EVQ:               rd32 = evq_base_val[RW-1:0];
      O_EVQ + 4:           rd32 = evq_base_val[DW-1:RW];
      O_EVQ_PROD:          rd32 = evq_prod_val;
      O_EVQ_CONS:          rd32 = evq_cons_val;
      default:             rd32 = '0;
    endcase
    for (int i = 0; i < NUM_ID; i++)
      if (off == OFF_W'(4 * i)) rd32 = id_vals[i*RW +: RW];
  end

  always_comb begin
    case (off)
      O_ECFG0: rd64 = err_cfg0_val;
      O_STAB:  rd64 = stab_base_val;
      O_CMDQ:  rd64 = cmdq_base_val;
      O_EVQ:   rd64 = evq_base_val;
      default: rd64 = '0;
    endcase
  end

  assign nxt_err  = req_write | ~(size4 | size8);
  assign nxt_data = nxt_err ? '0 : (size8 ? rd64 : {{RW{1'b0}}, rd32});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_error <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_data  <= req_valid ? nxt_data : '0;
      rsp_error <= req_valid & nxt_err;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R1
  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 4'd4 && req_size != 4'd8) |=> (rsp_error && rsp_data == '0)); // R3
  AST_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_error && rsp_data == '0)); // R4
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 4'd4) |=> (rsp_data[DW-1:RW] == '0 && !rsp_error)); // R5
  AST_WIDE_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 4'd8) |=> !rsp_error); // R7
endmodule

// File: tb/test_regbank_rd_decode.sv
`timescale 1ns/1ps
module test_regbank_rd_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_size = 4'd4;
  logic [16:0] req_offset = '0;
  logic [191:0] id_vals;
  logic [31:0] ctrl0_val = 32'hC0C0_0001, ctrl0_ack_val = 32'hC0AC_0002, ctrl1_val = 32'hC1C1_0003;
  logic [31:0] ctrl2_val = 32'hC2C2_0004, status_val = 32'h5757_0005, irq_ctrl_val = 32'h1A1A_0006;
  logic [31:0] err_val = 32'hEEEE_0007, err_ack_val = 32'hEAEA_0008;
  logic [31:0] err_cfg1_val = 32'hEC01_0009, err_cfg2_val = 32'hEC02_000A, stab_cfg_val = 32'h5CF0_000B;
  logic [31:0] cmdq_prod_val = 32'h0000_0013, cmdq_cons_val = 32'h0000_0011;
  logic [31:0] evq_prod_val = 32'h0000_0022, evq_cons_val = 32'h0000_0021;
  logic [63:0] err_cfg0_val  = 64'hE0E1_E2E3_E4E5_E6E7;
  logic [63:0] stab_base_val = 64'h5AB5_0000_1234_5000;
  logic [63:0] cmdq_base_val = 64'h0000_00AB_CDEF_0005;
  logic [63:0] evq_base_val  = 64'h0000_0077_8899_0007;
  logic rsp_valid, rsp_error;
  logic [63:0] rsp_data;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  regbank_rd_decode i_regbank_rd_decode (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_offset(req_offset), .id_vals(id_vals),
    .ctrl0_val(ctrl0_val), .ctrl0_ack_val(ctrl0_ack_val), .ctrl1_val(ctrl1_val),
    .ctrl2_val(ctrl2_val), .status_val(status_val), .irq_ctrl_val(irq_ctrl_val),
    .err_val(err_val), .err_ack_val(err_ack_val), .err_cfg0_val(err_cfg0_val),
    .err_cfg1_val(err_cfg1_val), .err_cfg2_val(err_cfg2_val), .stab_base_val(stab_base_val),
    .stab_cfg_val(stab_cfg_val), .cmdq_base_val(cmdq_base_val), .cmdq_prod_val(cmdq_prod_val),
    .cmdq_cons_val(cmdq_cons_val), .evq_base_val(evq_base_val), .evq_prod_val(evq_prod_val),
    .evq_cons_val(evq_cons_val), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_error(rsp_error)
  );

  task automatic chk(input string req, input logic [64:0] got, input logic [64:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(input string req, input logic wr, input logic [3:0] sz,
                        input logic [16:0] off, input logic [63:0] exp_d, input logic exp_e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(req, {rsp_valid, rsp_error, rsp_data[62:0]} , {1'b1, exp_e, exp_d[62:0]});
    chk(req, {1'b0, rsp_data}, {1'b0, exp_d});
  endtask

  task automatic t_reset();
    chk("R1 reset", {rsp_valid, rsp_error, rsp_data[62:0]}, '0);
  endtask

  task automatic t_timing();
    access("R1 response", 1'b0, 4'd4, 17'h020, {32'h0, ctrl0_val}, 1'b0);
    @(negedge clk);
    chk("R1 idle after response", {64'h0, rsp_valid}, '0);
  endtask

  task automatic t_ids();
    for (int i = 0; i < 6; i++)
      access("R10 id word", 1'b0, 4'd4, 17'(4 * i), {32'h0, id_vals[i*32 +: 32]}, 1'b0);
    access("R10 past last id", 1'b0, 4'd4, 17'h018, 64'h0, 1'b0);
  endtask

  task automatic t_map32();
    access("R5 ctrl0", 1'b0, 4'd4, 17'h020, {32'h0, ctrl0_val}, 1'b0);
    access("R5 ctrl0 ack", 1'b0, 4'd4, 17'h024, {32'h0, ctrl0_ack_val}, 1'b0);
    access("R5 ctrl1", 1'b0, 4'd4, 17'h028, {32'h0, ctrl1_val}, 1'b0);
    access("R5 ctrl2", 1'b0, 4'd4, 17'h02C, {32'h0, ctrl2_val}, 1'b0);
    access("R5 status", 1'b0, 4'd4, 17'h040, {32'h0, status_val}, 1'b0);
    access("R5 err", 1'b0, 4'd4, 17'h060, {32'h0, err_val}, 1'b0);
    access("R5 err ack", 1'b0, 4'd4, 17'h064, {32'h0, err_ack_val}, 1'b0);
    access("R5 err cfg1", 1'b0, 4'd4, 17'h070, {32'h0, err_cfg1_val}, 1'b0);
    access("R5 err cfg2", 1'b0, 4'd4, 17'h074, {32'h0, err_cfg2_val}, 1'b0);
    access("R5 stab cfg", 1'b0, 4'd4, 17'h088, {32'h0, stab_cfg_val}, 1'b0);
    access("R5 cmdq prod", 1'b0, 4'd4, 17'h098, {32'h0, cmdq_prod_val}, 1'b0);
    access("R5 cmdq cons", 1'b0, 4'd4, 17'h09C, {32'h0, cmdq_cons_val}, 1'b0);
    access("R5 evq prod", 1'b0, 4'd4, 17'h0A8, {32'h0, evq_prod_val}, 1'b0);
    access("R5 evq cons", 1'b0, 4'd4, 17'h0AC, {32'h0, evq_cons_val}, 1'b0);
  endtask

  task automatic t_irq();
    access("R9 irq ctrl", 1'b0, 4'd4, 17'h050, {32'h0, irq_ctrl_val}, 1'b0);
    access("R9 irq ack", 1'b0, 4'd4, 17'h054, {32'h0, irq_ctrl_val}, 1'b0);
  endtask

  task automatic t_halves();
    access("R6 ecfg0 lo", 1'b0, 4'd4, 17'h068, {32'h0, err_cfg0_val[31:0]}, 1'b0);
    access("R6 ecfg0 hi", 1'b0, 4'd4, 17'h06C, {32'h0, err_cfg0_val[63:32]}, 1'b0);
    access("R6 stab lo", 1'b0, 4'd4, 17'h080, {32'h0, stab_base_val[31:0]}, 1'b0);
    access("R6 stab hi", 1'b0, 4'd4, 17'h084, {32'h0, stab_base_val[63:32]}, 1'b0);
    access("R6 cmdq lo", 1'b0, 4'd4, 17'h090, {32'h0, cmdq_base_val[31:0]}, 1'b0);
    access("R6 cmdq hi", 1'b0, 4'd4, 17'h094, {32'h0, cmdq_base_val[63:32]}, 1'b0);
    access("R6 evq lo", 1'b0, 4'd4, 17'h0A0, {32'h0, evq_base_val[31:0]}, 1'b0);
    access("R6 evq hi", 1'b0, 4'd4, 17'h0A4, {32'h0, evq_base_val[63:32]}, 1'b0);
  endtask

  task automatic t_wide();
    access("R7 ecfg0 wide", 1'b0, 4'd8, 17'h068, err_cfg0_val, 1'b0);
    access("R7 stab wide", 1'b0, 4'd8, 17'h080, stab_base_val, 1'b0);
    access("R7 cmdq wide", 1'b0, 4'd8, 17'h090, cmdq_base_val, 1'b0);
    access("R7 evq wide", 1'b0, 4'd8, 17'h0A0, evq_base_val, 1'b0);
    access("R7 wide on narrow", 1'b0, 4'd8, 17'h020, 64'h0, 1'b0);
    access("R7 wide at upper half", 1'b0, 4'd8, 17'h084, 64'h0, 1'b0);
  endtask

  task automatic t_alias();
    access("R2 mirror ctrl0", 1'b0, 4'd4, 17'h10020, {32'h0, ctrl0_val}, 1'b0);
    access("R2 mirror id2", 1'b0, 4'd4, 17'h10008, {32'h0, id_vals[95:64]}, 1'b0);
    access("R2 mirror cmdq wide", 1'b0, 4'd8, 17'h10090, cmdq_base_val, 1'b0);
    access("R2 mirror evq hi", 1'b0, 4'd4, 17'h100A4, {32'h0, evq_base_val[63:32]}, 1'b0);
  endtask

  task automatic t_size();
    access("R3 size 1", 1'b0, 4'd1, 17'h020, 64'h0, 1'b1);
    access("R3 size 2", 1'b0, 4'd2, 17'h020, 64'h0, 1'b1);
    access("R3 size 0", 1'b0, 4'd0, 17'h068, 64'h0, 1'b1);
    access("R3 size 15", 1'b0, 4'd15, 17'h080, 64'h0, 1'b1);
  endtask

  task automatic t_write();
    access("R4 write 4", 1'b1, 4'd4, 17'h020, 64'h0, 1'b1);
    access("R4 write 8", 1'b1, 4'd8, 17'h090, 64'h0, 1'b1);
    access("R4 write unmapped", 1'b1, 4'd4, 17'h0F00, 64'h0, 1'b1);
  endtask

  task automatic t_unmapped();
    access("R8 gap", 1'b0, 4'd4, 17'h030, 64'h0, 1'b0);
    access("R8 high", 1'b0, 4'd4, 17'h0FFFC, 64'h0, 1'b0);
    access("R8 upper page high", 1'b0, 4'd4, 17'h1F000, 64'h0, 1'b0);
    access("R8 misaligned", 1'b0, 4'd4, 17'h022, 64'h0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) id_vals[i*32 +: 32] = 32'h1D00_0000 + 32'(i * 32'h0101_0101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_ids();
    t_map32();
    t_irq();
    t_halves();
    t_wide();
    t_alias();
    t_size();
    t_write();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule